// File: doc/BRIEF.md
# Multi-mode pixel serializer

This block sits between a video byte fetcher and the palette stage of a raster pipeline. For each raster line it pulls bytes over a valid/ready handshake and turns them into a stream of colour values, one per fine dot clock. A line is `2*LINE_DOTS` fine clocks wide, where `LINE_DOTS` is the standard line width. The same line period carries four pixel formats. The first is one bit per pixel at standard width, with each pixel held for two fine clocks. The second is one bit per pixel at double width, with a new pixel every fine clock; the fetcher interleaves the bytes of its two screen buffers, and this block takes them in the order they arrive. The third is a half-width format of two 4-bit palette indices per byte. The fourth is a quarter-resolution format of one 8-bit index per byte, repeated over two lines.

A `line_start` pulse opens a line and samples the format. Each output carries a flag. When the flag is low, `pix_index[0]` is a foreground/background bit that a later stage colours. When the flag is high, `pix_index` is a full palette index; the half-width format depends on the programmable palette being in use. A byte that is not ready when it is needed is replaced by the background index for that byte's whole span, and an underrun pulse is raised.

Top module: `pxs_serializer`

## Requirements
- R1: After reset, `pix_valid`, `underrun`, `pix_is_index`, `pix_index` and `fetch_ready` are all low.
- R2: `mode_sel` is sampled only in a cycle where `line_start` is high, and changes at other times have no effect. The line emits exactly `2*LINE_DOTS` outputs with `pix_valid` high, starting in the cycle after `line_start`.
- R3: With `mode_sel`=0 (standard), a line takes `LINE_DOTS/8` bytes. Bits go out MSB first, each held for 2 cycles, as `pix_index`={7'b0,bit} with `pix_is_index`=0.
- R4: With `mode_sel`=1 (double width), a line takes `LINE_DOTS/4` bytes. Bits go out MSB first, one per cycle, in the same format as R3.
- R5: With `mode_sel`=2 (half width, 4 bits per pixel), a line takes `LINE_DOTS/4` bytes. The high nibble goes out first, then the low nibble, each held for 4 cycles as {4'b0,nibble} with `pix_is_index`=1.
- R6: With `mode_sel`=3 (quarter resolution), a line takes `LINE_DOTS/2` bytes. Each byte goes out for 4 cycles as `pix_index` with `pix_is_index`=1.
- R7: Consecutive mode-3 lines alternate between fetch and repeat, and a mode-3 line that follows a line of any other mode is a fetch line. A repeat line raises `fetch_ready` in no cycle and outputs the values that the previous line stored.
- R8: `fetch_ready` is high only in the first cycle of each byte span and never for two cycles in a row within a line. A byte is taken only when `fetch_ready` and `fetch_valid` are both high.
- R9: If `fetch_valid` is low while `fetch_ready` is high, the whole span of that byte outputs `bg_index` with `pix_is_index`=1. `underrun` pulses for exactly the first output of that span. On a mode-3 fetch line the background value is stored, and the following repeat line outputs it without `underrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fine dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle pulse that opens a line |
| mode_sel | input | 2 | Pixel format, sampled with `line_start` |
| bg_index | input | 8 | Index output for missing bytes |
| fetch_valid | input | 1 | Fetcher offers a byte |
| fetch_data | input | 8 | Offered byte |
| fetch_ready | output | 1 | Serializer takes a byte this cycle |
| pix_valid | output | 1 | Output is a line pixel |
| pix_index | output | 8 | Pixel value or palette index |
| pix_is_index | output | 1 | `pix_index` is a full palette index |
| underrun | output | 1 | First output of a span whose byte was missing |

## Verification
Each format is first driven with a distinct pseudo-random byte stream and a fully ready fetcher. This separates the per-mode hold times, the bit and nibble order, and the number of bytes taken per line. The streams are then repeated with every third, fourth or fifth byte withheld, which tells a span-long background fill apart from a single bad dot. Sequences of mode-3 lines that are broken by other modes show whether repeat lines alternate, whether parity restarts, and whether stored background is replayed. `mode_sel` is changed in the middle of a line to show that only `line_start` samples it.

// File: rtl/pxs_pkg.sv
package pxs_pkg;

  typedef enum logic [1:0] {
    MODE_STD   = 2'd0,
    MODE_HIRES = 2'd1,
    MODE_NIB   = 2'd2,
    MODE_QTR   = 2'd3
  } pix_mode_e;

  // log2 of fine clocks spent on one fetched byte
  function automatic logic [2:0] span_log2(pix_mode_e m);
    case (m)
      MODE_STD:   return 3'd4;
      MODE_HIRES: return 3'd3;
      MODE_NIB:   return 3'd3;
      default:    return 3'd2;
    endcase
  endfunction

  // log2 of fine clocks each pixel is held
  function automatic logic [1:0] hold_log2(pix_mode_e m);
    case (m)
      MODE_STD:   return 2'd1;
      MODE_HIRES: return 2'd0;
      default:    return 2'd2;
    endcase
  endfunction

  // pixel number idx of byte b, most significant first
  function automatic logic [7:0] pick_pixel(logic [7:0] b, pix_mode_e m, logic [2:0] idx);
    case (m)
      MODE_STD, MODE_HIRES: return {7'd0, b[3'd7 - idx]};
      MODE_NIB:             return idx[0] ? {4'd0, b[3:0]} : {4'd0, b[7:4]};
      default:              return b;
    endcase
  endfunction

  function automatic logic carries_index(pix_mode_e m);
    return (m == MODE_NIB) || (m == MODE_QTR);
  endfunction

endpackage

// File: rtl/pxs_line_seq.sv
module pxs_line_seq
  import pxs_pkg::*;
#(
  parameter int LINE_DOTS = 256,
  localparam int FINE = 2 * LINE_DOTS,
  localparam int TICK_W = $clog2(FINE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_start,
  input  logic [1:0]        mode_sel,
  output logic              active,
  output pix_mode_e         mode,
  output logic [TICK_W-1:0] tick,
  output logic              slot_start,
  output logic [2:0]        pix_idx,
  output logic              replay,
  output logic              record
);

  pix_mode_e         new_mode;
  logic              odd_q;
  logic [TICK_W-1:0] span_mask;
  logic [TICK_W-1:0] pos_rel;

  assign new_mode = pix_mode_e'(mode_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      tick   <= '0;
      mode   <= MODE_STD;
      odd_q  <= 1'b0;
    end else if (line_start) begin
      active <= 1'b1;
      tick   <= '0;
      mode   <= new_mode;
      odd_q  <= (new_mode == MODE_QTR && mode == MODE_QTR) ? ~odd_q : 1'b0;
    end else if (active) begin
      tick <= tick + 1'b1;
      if (tick == TICK_W'(FINE - 1)) active <= 1'b0;
    end
  end

  assign span_mask  = ~({TICK_W{1'b1}} << span_log2(mode));
  assign pos_rel    = (tick & span_mask) >> hold_log2(mode);
  assign pix_idx    = pos_rel[2:0];
  assign slot_start = active && ((tick & span_mask) == '0);
  assign replay     = active && (mode == MODE_QTR) && odd_q;
  assign record     = active && (mode == MODE_QTR) && !odd_q;

endmodule

// File: rtl/pxs_line_buf.sv
module pxs_line_buf #(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pxs_pix_out.sv
module pxs_pix_out
  import pxs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       active,
  input  pix_mode_e  mode,
  input  logic [2:0] pix_idx,
  input  logic [7:0] src_byte,
  input  logic       eff_miss,
  input  logic       miss_now,
  input  logic [7:0] bg_index,
  output logic       pix_valid,
  output logic [7:0] pix_index,
  output logic       pix_is_index,
  output logic       underrun
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_valid    <= 1'b0;
      pix_index    <= '0;
      pix_is_index <= 1'b0;
      underrun     <= 1'b0;
    end else begin
      pix_valid <= active;
      underrun  <= active && miss_now;
      if (!active) begin
        pix_index    <= '0;
        pix_is_index <= 1'b0;
      end else if (eff_miss) begin
        pix_index    <= bg_index;
        pix_is_index <= 1'b1;
      end else begin
        pix_index    <= pick_pixel(src_byte, mode, pix_idx);
        pix_is_index <= carries_index(mode);
      end
    end
  end

endmodule

// File: rtl/pxs_serializer.sv
module pxs_serializer
  import pxs_pkg::*;
#(
  parameter int LINE_DOTS = 256
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_start,
  input  logic [1:0] mode_sel,
  input  logic [7:0] bg_index,
  input  logic       fetch_valid,
  input  logic [7:0] fetch_data,
  output logic       fetch_ready,
  output logic       pix_valid,
  output logic [7:0] pix_index,
  output logic       pix_is_index,
  output logic       underrun
);

  localparam int FINE   = 2 * LINE_DOTS;
  localparam int TICK_W = $clog2(FINE);
  localparam int LB_DEP = FINE / 4;
  localparam int LB_AW  = $clog2(LB_DEP);

  logic              active_q;
  pix_mode_e         mode_q;
  logic [TICK_W-1:0] tick;
  logic              slot_start;
  logic [2:0]        pix_idx;
  logic              replay;
  logic              record;
  logic [7:0]        lb_rdata;
  logic [LB_AW-1:0]  lb_addr;
  logic [7:0]        cur_byte;
  logic              miss_slot;
  logic              miss_now;
  logic [7:0]        fresh_byte;
  logic [7:0]        src_byte;
  logic              eff_miss;

  pxs_line_seq #(.LINE_DOTS(LINE_DOTS)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_start (line_start),
    .mode_sel   (mode_sel),
    .active     (active_q),
    .mode       (mode_q),
    .tick       (tick),
    .slot_start (slot_start),
    .pix_idx    (pix_idx),
    .replay     (replay),
    .record     (record)
  );

  assign fetch_ready = slot_start && !replay;
  assign miss_now    = fetch_ready && !fetch_valid;
  assign lb_addr     = tick[TICK_W-1:2];

  pxs_line_buf #(.DEPTH(LB_DEP)) u_buf (
    .clk   (clk),
    .we    (slot_start && record),
    .waddr (lb_addr),
    .wdata (fetch_valid ? fetch_data : bg_index),
    .raddr (lb_addr),
    .rdata (lb_rdata)
  );

  assign fresh_byte = replay ? lb_rdata : fetch_data;
  assign src_byte   = slot_start ? fresh_byte : cur_byte;
  assign eff_miss   = slot_start ? miss_now : miss_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_byte  <= '0;
      miss_slot <= 1'b0;
    end else if (slot_start) begin
      cur_byte  <= fresh_byte;
      miss_slot <= miss_now;
    end
  end

  pxs_pix_out u_out (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (active_q),
    .mode         (mode_q),
    .pix_idx      (pix_idx),
    .src_byte     (src_byte),
    .eff_miss     (eff_miss),
    .miss_now     (miss_now),
    .bg_index     (bg_index),
    .pix_valid    (pix_valid),
    .pix_index    (pix_index),
    .pix_is_index (pix_is_index),
    .underrun     (underrun)
  );

endmodule

// File: rtl/pxs_serializer_chk.sv
module pxs_serializer_chk #(
  parameter int LINE_DOTS = 256
) (
  input logic       clk,
  input logic       rst_n,
  input logic       line_start,
  input logic       fetch_ready,
  input logic       pix_valid,
  input logic       pix_is_index,
  input logic       underrun,
  input logic       active_q,
  input logic [1:0] mode_bits,
  input logic [7:0] pix_index,
  input logic [7:0] bg_index
);

  localparam int FINE  = 2 * LINE_DOTS;
  localparam int CNT_W = $clog2(FINE + 2) + 1;

  logic [CNT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          run_cnt <= '0;
    else if (line_start) run_cnt <= '0;
    else if (pix_valid)  run_cnt <= run_cnt + 1'b1;
    else                 run_cnt <= '0;
  end

  // R2
  line_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CNT_W'(FINE));

  // R2
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !line_start) |=> $stable(mode_bits));

  // R2
  first_pix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |=> pix_valid);

  // R3
  bit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !pix_is_index) |-> (pix_index[7:1] == 7'd0));

  // R8
  ready_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_ready && !line_start) |=> !fetch_ready);

  // R9
  underrun_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> (pix_is_index && pix_index == $past(bg_index)));

  // R9
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> !underrun);

endmodule

bind pxs_serializer pxs_serializer_chk #(.LINE_DOTS(LINE_DOTS)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_start   (line_start),
  .fetch_ready  (fetch_ready),
  .pix_valid    (pix_valid),
  .pix_is_index (pix_is_index),
  .underrun     (underrun),
  .active_q     (active_q),
  .mode_bits    (mode_q),
  .pix_index    (pix_index),
  .bg_index     (bg_index)
);

// File: tb/tb_pxs_serializer.sv
module tb_pxs_serializer;

  localparam int LINE_DOTS = 256;
  localparam int FINE = 2 * LINE_DOTS;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_start = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic [7:0] bg_index = 8'h00;
  logic       fetch_valid = 1'b0;
  logic [7:0] fetch_data = 8'h00;
  logic       fetch_ready;
  logic       pix_valid;
  logic [7:0] pix_index;
  logic       pix_is_index;
  logic       underrun;

  pxs_serializer #(.LINE_DOTS(LINE_DOTS)) dut (.*);

  always #5 clk = ~clk;

  typedef struct packed {
    logic [3:0] req;
    logic [7:0] idx;
    logic       flag;
    logic       urun;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int failures = 0;
  logic [7:0] qtr_mem [FINE/4];
  logic [1:0] prev_mode = 2'd0;
  logic       prev_odd = 1'b0;
  logic       done = 1'b0;

  function automatic logic [7:0] byte_of(int seed, int s);
    return 8'(seed * 53 + s * 29 + (s >> 2) * 7);
  endfunction

  function automatic logic missing(int s, int every);
    return (every > 0) && ((s % every) == every - 1);
  endfunction

  task automatic check(input string req, input logic ok, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  // monitor: pops the scoreboard on each valid output
  always @(negedge clk) begin
    if (rst_n && pix_valid && !done) begin
      if (exp_q.size() == 0) begin
        check("R2 extra pixel", 1'b0, 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check($sformatf("R%0d pixel", e.req),
              {pix_index, pix_is_index, underrun} == {e.idx, e.flag, e.urun},
              {pix_index, pix_is_index, underrun}, {e.idx, e.flag, e.urun});
      end
    end
  end

  task automatic run_line(input logic [1:0] m, input int seed, input int every,
                          input logic [1:0] noise, input logic [7:0] bg);
    int sh;
    int span;
    int takes;
    int exp_takes;
    int ready_rep;
    logic odd;
    odd = (m == 2'd3 && prev_mode == 2'd3) ? !prev_odd : 1'b0; // R7 parity
    prev_odd = odd;
    prev_mode = m;
    sh = (m == 2'd0) ? 4 : (m == 2'd3) ? 2 : 3;
    span = 1 << sh;
    exp_takes = 0;
    for (int k = 0; k < FINE; k++) begin
      int s;
      int p;
      logic [7:0] v;
      exp_t e;
      s = k >> sh;
      p = k % span;
      if (m == 2'd3 && odd) begin
        e = '{req: 4'd7, idx: qtr_mem[s], flag: 1'b1, urun: 1'b0}; // R7 replay
      end else if (missing(s, every)) begin
        e = '{req: 4'd9, idx: bg, flag: 1'b1, urun: (p == 0)}; // R9
        if (m == 2'd3) qtr_mem[s] = bg;
      end else begin
        v = byte_of(seed, s);
        if (p == 0) exp_takes++;
        case (m)
          2'd0: e = '{req: 4'd3, idx: {7'd0, v[7 - p / 2]}, flag: 1'b0, urun: 1'b0}; // R3
          2'd1: e = '{req: 4'd4, idx: {7'd0, v[7 - p]}, flag: 1'b0, urun: 1'b0};     // R4
          2'd2: e = '{req: 4'd5, idx: (p < 4) ? {4'd0, v[7:4]} : {4'd0, v[3:0]},
                      flag: 1'b1, urun: 1'b0};                                     // R5
          default: begin
            e = '{req: 4'd6, idx: v, flag: 1'b1, urun: 1'b0};                      // R6
            qtr_mem[s] = v;
          end
        endcase
      end
      exp_q.push_back(e);
    end
    bg_index = bg;
    @(negedge clk);
    line_start = 1'b1;
    mode_sel = m;
    @(negedge clk);
    line_start = 1'b0;
    mode_sel = noise; // R2: ignored mid-line
    check("R2 no pixel in start cycle", pix_valid == 1'b0, pix_valid, 0);
    takes = 0;
    ready_rep = 0;
    for (int k = 0; k < FINE; k++) begin
      int s;
      s = k >> sh;
      fetch_valid = !(m == 2'd3 && odd) && !missing(s, every);
      fetch_data = byte_of(seed, s);
      #1;
      if (fetch_ready && fetch_valid) takes++;
      if (odd && fetch_ready) ready_rep++;
      @(negedge clk);
    end
    fetch_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R2 line length", exp_q.size() == 0, exp_q.size(), 0);
    check("R2 idle after line", pix_valid == 1'b0, pix_valid, 0);
    check("R8 bytes taken", takes == exp_takes, takes, exp_takes);
    check("R7 no ready on repeat line", ready_rep == 0, ready_rep, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pix_valid", pix_valid == 1'b0, pix_valid, 0);
    check("R1 underrun", underrun == 1'b0, underrun, 0);
    check("R1 fetch_ready", fetch_ready == 1'b0, fetch_ready, 0);
    check("R1 pix_index", {pix_index, pix_is_index} == 9'd0, {pix_index, pix_is_index}, 0);

    run_line(2'd0, 1, 0, 2'd3, 8'h11); // R3, R2 noise
    run_line(2'd1, 2, 0, 2'd2, 8'h22); // R4
    run_line(2'd2, 3, 0, 2'd0, 8'h33); // R5
    run_line(2'd3, 4, 0, 2'd1, 8'h44); // R6 fetch
    run_line(2'd3, 5, 0, 2'd0, 8'h55); // R7 repeat
    run_line(2'd3, 6, 0, 2'd2, 8'h66); // R7 fetch again
    run_line(2'd0, 7, 3, 2'd1, 8'hA5); // R9 standard
    run_line(2'd1, 8, 5, 2'd3, 8'h5A); // R9 double width
    run_line(2'd2, 9, 4, 2'd3, 8'hC3); // R9 nibbles
    run_line(2'd3, 10, 3, 2'd0, 8'h3C); // R9 fetch line stores bg
    run_line(2'd3, 11, 0, 2'd1, 8'h99); // R9 repeat line replays bg
    run_line(2'd0, 12, 0, 2'd3, 8'h01);
    run_line(2'd3, 13, 0, 2'd0, 8'h02); // R7 parity restarts
    run_line(2'd3, 14, 0, 2'd0, 8'h03); // R7 repeat

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog got=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule